// File: doc/BRIEF.md
# Synchronous Receive Character Aligner

This block finds character boundaries in a synchronous serial bit stream. After reset, or whenever the control logic asks for it, the block is in hunt mode. In hunt mode it shifts one received bit into a window register on every receive-clock strobe. After each bit it compares the window with a programmed first sync word. In dual-sync mode, a first match is followed by a check of the next full character against a second sync word.

Once alignment is found, the block leaves hunt and raises a sync-detected flag. From then on it cuts the stream into characters at the boundary it found. Each character is presented with a one-cycle valid strobe. The sync-detected flag stays high until a status read clears it.

The block also has an external-sync setting. In that setting the internal search is off, and a high level on an external sync input ends hunt directly. A new hunt request drops the current alignment at any time.

Top module: `sync_hunter`

## Requirements
- R1: After reset, `hunting` is 1, `sync_det` is 0 and `char_valid` is 0.
- R2: A bit is taken from `rx_data` only in a cycle where `rx_tick` is 1. The first bit received of a character lands in the MSB of `char_out`, and the window is compared MSB-first against the sync words.
- R3: In single-sync mode, `sync_det` rises and `hunting` falls in the cycle after the tick whose bit completes a window equal to `sync1`. Neither changes earlier.
- R4: After entry into hunt, no comparison is made until CHAR_W bits have been received since that entry.
- R5: In dual-sync mode (`cfg_dual`=1), a `sync1` match leaves `hunting` at 1. Lock and `sync_det` follow only if the next CHAR_W bits equal `sync2`.
- R6: In dual-sync mode, if the character after a `sync1` match differs from `sync2`, `sync_det` stays 0. The search for `sync1` then resumes bit by bit with the bits already in the window.
- R7: Once locked, every CHAR_W ticks deliver one character on `char_out`, with `char_valid` high for exactly one cycle. The first character starts with the tick after the sync boundary. `char_valid` is never high while hunting.
- R8: A `status_rd` pulse clears `sync_det` in the next cycle and leaves the lock in place. A set in the same cycle wins over the clear.
- R9: With `cfg_ext`=1, no internal comparison takes place. A high `ext_sync_in` while hunting ends hunt at the next edge, without raising `sync_det`, and framing starts with the next tick.
- R10: A `hunt_cmd` pulse returns the block to hunting at the next edge, whatever its state. It drops any partial character, restarts the R4 bit count, and takes priority over every other input in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_tick | input | 1 | One-cycle strobe marking a rising edge of the receive clock |
| rx_data | input | 1 | Serial receive data |
| hunt_cmd | input | 1 | Request to re-enter hunt mode |
| cfg_dual | input | 1 | 1: two sync words, 0: one |
| cfg_ext | input | 1 | 1: external sync, internal search off |
| sync1 | input | CHAR_W | First sync word |
| sync2 | input | CHAR_W | Second sync word |
| ext_sync_in | input | 1 | External sync level, used when `cfg_ext`=1 |
| status_rd | input | 1 | Status read pulse; clears `sync_det` |
| char_out | output | CHAR_W | Last assembled character |
| char_valid | output | 1 | One-cycle strobe for a new character |
| sync_det | output | 1 | Sync-detected flag |
| hunting | output | 1 | 1 while in hunt mode |

## Verification
The properties assume that the configuration inputs and sync words change only while a hunt request is active. They also assume that `ext_sync_in` is never high in the same cycle as `rx_tick`, because otherwise the fate of that bit would be a matter of priority rather than behaviour. The stimulus changes configuration only alongside a `hunt_cmd` pulse. It pulses `ext_sync_in` in a cycle with no tick, and it chooses the preamble bits of each vector so that no window matches a sync word before the intended boundary.

// File: rtl/sync_hunter.sv
module sync_hunter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_tick,
  input  logic              rx_data,
  input  logic              hunt_cmd,
  input  logic              cfg_dual,
  input  logic              cfg_ext,
  input  logic [CHAR_W-1:0] sync1,
  input  logic [CHAR_W-1:0] sync2,
  input  logic              ext_sync_in,
  input  logic              status_rd,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_valid,
  output logic              sync_det,
  output logic              hunting
);
  localparam int CW = $clog2(CHAR_W + 1);
  localparam logic [CW-1:0] FULL = CW'(CHAR_W);
  localparam logic [CW-1:0] LAST = CW'(CHAR_W - 1);

  typedef enum logic [1:0] {ST_HUNT1, ST_HUNT2, ST_LOCK} st_t;
  st_t st;

  logic [CHAR_W-1:0] win;
  logic [CW-1:0]     fill, bitcnt;

  wire [CHAR_W-1:0] win_nx  = {win[CHAR_W-2:0], rx_data};
  wire              enough  = (fill >= LAST);
  wire              lastbit = (bitcnt == LAST);

  assign hunting = (st != ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_HUNT1;
      win        <= '0;
      fill       <= '0;
      bitcnt     <= '0;
      char_out   <= '0;
      char_valid <= 1'b0;
      sync_det   <= 1'b0;
    end else begin
      char_valid <= 1'b0;
      if (status_rd) sync_det <= 1'b0;
      if (hunt_cmd) begin
        st     <= ST_HUNT1;
        fill   <= '0;
        bitcnt <= '0;
      end else if (cfg_ext && hunting && ext_sync_in) begin
        st     <= ST_LOCK;
        bitcnt <= '0;
      end else if (rx_tick) begin
        win <= win_nx;
        if (fill != FULL) fill <= fill + 1'b1;
        case (st)
          ST_HUNT1: begin
            if (!cfg_ext && enough && win_nx == sync1) begin
              bitcnt <= '0;
              if (cfg_dual) st <= ST_HUNT2;
              else begin
                st       <= ST_LOCK;
                sync_det <= 1'b1;
              end
            end
          end
          ST_HUNT2: begin
            if (lastbit) begin
              bitcnt <= '0;
              if (win_nx == sync2) begin
                st       <= ST_LOCK;
                sync_det <= 1'b1;
              end else begin
                st <= ST_HUNT1;
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          default: begin
            if (lastbit) begin
              bitcnt     <= '0;
              char_out   <= win_nx;
              char_valid <= 1'b1;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);
  // R7
  valid_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> !hunting);
  // R3
  det_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_det) |-> !hunting && $past(rx_tick));
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !rx_tick |=> !sync_det);
  // R9
  ext_nodet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext && $past(cfg_ext) |-> !$rose(sync_det));
  // R9
  ext_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext && hunting && ext_sync_in && !hunt_cmd |=> !hunting);
  // R10
  hunt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_cmd |=> hunting && !char_valid);
endmodule

// File: tb/sim_sync_hunter.sv
module sim_sync_hunter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  // {dual, sync1, sync2, pre_len[2:0], pre[7:0], data}
  localparam logic [35:0] VEC [0:3] = '{
    {1'b0, 8'h16, 8'h00, 3'd5, 8'h15, 8'hA5},
    {1'b1, 8'h16, 8'h16, 3'd3, 8'h07, 8'h3C},
    {1'b0, 8'h7E, 8'h00, 3'd4, 8'h00, 8'h81},
    {1'b1, 8'hA5, 8'h5A, 3'd1, 8'h01, 8'hF0}
  };

  logic clk = 0, rst_n = 0;
  logic rx_tick = 0, rx_data = 0, hunt_cmd = 0, cfg_dual = 0, cfg_ext = 0;
  logic [W-1:0] sync1 = 0, sync2 = 0;
  logic ext_sync_in = 0, status_rd = 0;
  logic [W-1:0] char_out;
  logic char_valid, sync_det, hunting;

  int checks = 0, errors = 0, nval = 0;
  logic [W-1:0] lastc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hunter #(.CHAR_W(W)) u0 (
    .clk, .rst_n, .rx_tick, .rx_data, .hunt_cmd, .cfg_dual, .cfg_ext,
    .sync1, .sync2, .ext_sync_in, .status_rd,
    .char_out, .char_valid, .sync_det, .hunting);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    rx_data = b; rx_tick = 1;
    @(negedge clk);
    rx_tick = 0;
    if (char_valid) begin nval++; lastc = char_out; end
    @(negedge clk);
    if (char_valid) begin nval++; lastc = char_out; end
  endtask

  task automatic send_bits(input logic [W-1:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic pulse_hunt();
    hunt_cmd = 1; @(negedge clk); hunt_cmd = 0;
  endtask

  task automatic pulse_rd();
    status_rd = 1; @(negedge clk); status_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(hunting == 1 && sync_det == 0 && char_valid == 0, "R1 reset state",
          {hunting, sync_det, char_valid}, 3'b100);

    for (int v = 0; v < 4; v++) begin
      logic [W-1:0] s1, s2, d, lastsync;
      logic dual;
      dual = VEC[v][35]; s1 = VEC[v][34:27]; s2 = VEC[v][26:19]; d = VEC[v][7:0];
      cfg_dual = dual; sync1 = s1; sync2 = s2; cfg_ext = 0;
      pulse_hunt();
      pulse_rd();
      send_bits(VEC[v][15:8], int'(VEC[v][18:16]));
      if (dual) begin
        send_bits(s1, W);
        check(hunting == 1 && sync_det == 0, "R5 still hunting after first word", {hunting, sync_det}, 2'b10);
      end
      lastsync = dual ? s2 : s1;
      send_bits(lastsync >> 1, W - 1);
      check(sync_det == 0 && hunting == 1, "R3 no detect before boundary", {hunting, sync_det}, 2'b10);
      tick(lastsync[0]);
      check(sync_det == 1 && hunting == 0, dual ? "R5 dual lock" : "R3 single lock", {hunting, sync_det}, 2'b01);
      nval = 0;
      send_bits(d, W);
      check(nval == 1 && lastc == d, "R2 R7 first char", {nval[7:0], lastc}, {8'd1, d});
      send_bits(~d, W);
      check(nval == 2 && lastc == ~d, "R7 second char", {nval[7:0], lastc}, {8'd2, ~d});
      pulse_rd();
      check(sync_det == 0 && hunting == 0, "R8 read clears flag keeps lock", {hunting, sync_det}, 2'b00);
    end

    // R6: dual mismatch falls back to bit search
    cfg_dual = 1; sync1 = 8'h16; sync2 = 8'h16;
    pulse_hunt(); pulse_rd();
    send_bits(8'h16, W);
    send_bits(8'hFF, W);
    check(sync_det == 0 && hunting == 1, "R6 mismatch stays hunting", {hunting, sync_det}, 2'b10);
    send_bits(8'h16, W);
    send_bits(8'h16, W);
    check(sync_det == 1 && hunting == 0, "R6 resumed search locks", {hunting, sync_det}, 2'b01);

    // R4: no compare before CHAR_W bits
    cfg_dual = 0; sync1 = 8'h00;
    pulse_hunt(); pulse_rd();
    send_bits(8'h00, W - 1);
    check(sync_det == 0 && hunting == 1, "R4 seven bits no match", {hunting, sync_det}, 2'b10);
    tick(1'b0);
    check(sync_det == 1 && hunting == 0, "R4 eighth bit match", {hunting, sync_det}, 2'b01);

    // R10: hunt request mid-character
    sync1 = 8'h16;
    pulse_hunt(); pulse_rd();
    send_bits(8'h16, W);
    send_bits(8'h05, 3);
    nval = 0;
    pulse_hunt();
    check(hunting == 1, "R10 back to hunting", hunting, 1);
    send_bits(8'hFF, W);
    check(nval == 0 && hunting == 1, "R10 partial char dropped", {nval[7:0], 7'd0, hunting}, 16'h0001);

    // R9: external sync
    cfg_ext = 1;
    pulse_hunt(); pulse_rd();
    send_bits(8'h16, W);
    send_bits(8'h16, W);
    check(hunting == 1 && sync_det == 0, "R9 internal search off", {hunting, sync_det}, 2'b10);
    ext_sync_in = 1; @(negedge clk); ext_sync_in = 0;
    check(hunting == 0 && sync_det == 0, "R9 external lock no flag", {hunting, sync_det}, 2'b00);
    nval = 0;
    send_bits(8'hC3, W);
    check(nval == 1 && lastc == 8'hC3, "R9 framing after external lock", {nval[7:0], lastc}, 16'h01C3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule